// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer

This block is a 16-bit up-counter that advances on a one-cycle count-tick enable. It has two 16-bit registers, CR0 and CR1. A control bit for each register sets whether it works as a compare value or as a capture latch. The counter can run freely, restart from zero when a pulse arrives on the trigger input, or restart from zero after it reaches the CR0 value. The block drives a timer output that toggles on events, a one-cycle interrupt pulse, and a sticky overflow flag.

Software reaches the block through a small write port at three addresses:

| Address | Contents |
|---|---|
| 0 | Control word |
| 1 | CR0 |
| 2 | CR1 |

The counter and both registers can be read at all times on output ports. The trigger input (`trig_evt`) and the second capture input (`cap_evt`) arrive as synchronised one-cycle pulses.

Top module: `cc_timer16`

## Requirements
- R1: After reset, the counter, CR0, CR1, the timer output, the interrupt and the overflow flag are all 0, and the mode is 000.
- R2: The mode sits in control bits [3:1]. With mode 000 or 001 the counter is held at 0. While stopped, count ticks and pulses on `trig_evt` and `cap_evt` do not count, capture, toggle the output or raise an interrupt.
- R3: With mode 010 or 011 the counter adds one on every tick and rolls from FFFFH to 0000H. With the block running and no tick, the counter holds its value.
- R4: With mode 100 or 101, a `trig_evt` pulse loads 0 into the counter and toggles the timer output. If a tick arrives in the same cycle, the clear still wins.
- R5: With mode 110 or 111, a tick while the counter equals a compare-mode CR0 loads 0 instead of adding one, so one period is CR0+1 ticks.
- R6: A tick while the counter equals a compare-mode CR0 or CR1 toggles the timer output. It also sets `irq_o` high for exactly one cycle, in the cycle after that tick.
- R7: The overflow flag sets when a tick rolls the counter from FFFFH to 0. This applies in modes 01x and 10x, and in modes 11x only when CR0 is FFFFH. A restart at a smaller CR0 does not set the flag.
- R8: Writing control bit 0 as 0 clears the overflow flag, and writing it as 1 has no effect. A clear made after a rollover but before the next tick is ignored.
- R9: Control bit 4 makes CR0 a capture latch for `trig_evt`, and bit 5 makes CR1 a capture latch for `cap_evt`. A capture stores the counter value of the pulse cycle. Its interrupt is raised on the first tick after the pulse, with `irq_o` high in the cycle after that tick.
- R10: While the block is running, a control write changes the mode only when the new mode is a stopped code (bits [3:2] = 00), and it never changes bits 4 and 5. Bit 0 still acts as described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | One-cycle count enable |
| trig_evt | input | 1 | Synchronised trigger pulse (restart/capture into CR0) |
| cap_evt | input | 1 | Synchronised capture pulse for CR1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 CR0, 2 CR1 |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Counter value |
| cr0_o | output | 16 | CR0 contents |
| cr1_o | output | 16 | CR1 contents |
| ovf_o | output | 1 | Sticky overflow flag |
| tout_o | output | 1 | Toggling timer output |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that `cnt_tick`, `trig_evt` and `cap_evt` are single-cycle pulses that are already synchronous to `clk`. They also assume that the only thing that changes the counter, apart from a tick, is a trigger-driven clear. The stimulus drives every input 1 ns after a rising edge and holds it for exactly one cycle. A long run of ticks reaches the FFFFH rollover in free-running mode, and software clears are placed on both sides of the first tick after the wrap.

// File: rtl/cc_timer16.sv
module cc_timer16 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         trig_evt,
  input  logic         cap_evt,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cr0_o,
  output logic [W-1:0] cr1_o,
  output logic         ovf_o,
  output logic         tout_o,
  output logic         irq_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt, cr0, cr1;
  logic [2:0]   mode;
  logic         cap0, cap1, ovf, wrap_hold, tout, irq, cap_pend;
  logic         run, edge_mode, match_mode, t0, t1, adv;
  logic         m0, m1, clr, wrap, wr_ctl, ovf_clr, cap_ev0, cap_ev1, cap_irq;

  assign run        = mode[2:1] != 2'b00;
  assign edge_mode  = mode[2:1] == 2'b10;
  assign match_mode = mode[2:1] == 2'b11;
  assign t0         = run & trig_evt;
  assign t1         = run & cap_evt;
  assign adv        = run & cnt_tick;

  assign m0 = adv & ~cap0 & (cnt == cr0);
  assign m1 = adv & ~cap1 & (cnt == cr1);

  assign clr  = ~run | (edge_mode & t0) | (match_mode & m0);
  assign wrap = adv & (cnt == TOP) & ~(edge_mode & t0) & (~match_mode | (cr0 == TOP));

  assign cap_ev0 = t0 & cap0;
  assign cap_ev1 = t1 & cap1;
  assign cap_irq = cap_pend & adv;

  assign wr_ctl  = wr_en & (wr_addr == 2'd0);
  assign ovf_clr = wr_ctl & ~wr_data[0] & ~wrap_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      cr0       <= '0;
      cr1       <= '0;
      mode      <= 3'b000;
      cap0      <= 1'b0;
      cap1      <= 1'b0;
      ovf       <= 1'b0;
      wrap_hold <= 1'b0;
      tout      <= 1'b0;
      irq       <= 1'b0;
      cap_pend  <= 1'b0;
    end else begin
      if (clr)      cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;

      if (wr_ctl && (!run || wr_data[3:2] == 2'b00)) mode <= wr_data[3:1];
      if (wr_ctl && !run) begin
        cap0 <= wr_data[4];
        cap1 <= wr_data[5];
      end

      if (cap_ev0)                          cr0 <= cnt;
      else if (wr_en && wr_addr == 2'd1)    cr0 <= wr_data;
      if (cap_ev1)                          cr1 <= cnt;
      else if (wr_en && wr_addr == 2'd2)    cr1 <= wr_data;

      ovf       <= wrap | (ovf & ~ovf_clr);
      wrap_hold <= wrap | (wrap_hold & run & ~adv);
      tout      <= tout ^ (m0 | m1 | (edge_mode & t0));
      irq       <= m0 | m1 | cap_irq;
      cap_pend  <= run & (cap_ev0 | cap_ev1 | (cap_pend & ~adv));
    end
  end

  assign count_o = cnt;
  assign cr0_o   = cr0;
  assign cr1_o   = cr1;
  assign ovf_o   = ovf;
  assign tout_o  = tout;
  assign irq_o   = irq;
endmodule

// File: rtl/cc_timer16_chk.sv
module cc_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_tick,
  input logic         trig_evt,
  input logic         wr_ctl,
  input logic         wr_run,
  input logic [2:0]   mode,
  input logic [W-1:0] cnt,
  input logic         ovf,
  input logic         tout,
  input logic         irq
);
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b00) |=> (cnt == '0)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] != 2'b00 && !cnt_tick && !trig_evt) |=> $stable(cnt)); // R3
  AST_TOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tout != $past(tout)) |-> ($past(cnt_tick) || $past(trig_evt))); // R4
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cnt_tick)); // R6
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(cnt) == '1 && cnt == '0)); // R7
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] != 2'b00 && wr_ctl && wr_run) |=> $stable(mode)); // R10
endmodule

bind cc_timer16 cc_timer16_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_tick (cnt_tick),
  .trig_evt (trig_evt),
  .wr_ctl   (wr_en && wr_addr == 2'd0),
  .wr_run   (wr_data[3:2] != 2'b00),
  .mode     (mode),
  .cnt      (cnt),
  .ovf      (ovf),
  .tout     (tout),
  .irq      (irq)
);

// File: tb/test_cc_timer16.sv
module test_cc_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0, trig_evt = 1'b0, cap_evt = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count_o, cr0_o, cr1_o;
  logic        ovf_o, tout_o, irq_o;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cc_timer16 i_cc_timer16 (.*);

  // {tick, trig, cap, expected count, expected tout, expected irq}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'd2, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd3, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic t0, input logic t1);
    cnt_tick = tk; trig_evt = t0; cap_evt = t1;
    @(posedge clk); #1;
    cnt_tick = 1'b0; trig_evt = 1'b0; cap_evt = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count_o, 0); chk("R1 tout", tout_o, 0);
    chk("R1 irq", irq_o, 0);     chk("R1 ovf", ovf_o, 0);
    chk("R1 cr0", cr0_o, 0);

    // R2 stopped: nothing moves, no capture even with bit4 set
    wr(2'd0, 16'h0011);
    step(1, 1, 1);
    chk("R2 count", count_o, 0); chk("R2 irq", irq_o, 0);
    chk("R2 tout", tout_o, 0);   chk("R2 cr0", cr0_o, 0);
    step(1, 0, 0);
    chk("R2 count held", count_o, 0);

    // R5/R6 table: mode 110, CR0=3, CR1=1, compare
    wr(2'd1, 16'd3); wr(2'd2, 16'd1); wr(2'd0, 16'h000D);
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18]);
      chk("R5 count", count_o, VEC[i][17:2]);
      chk("R6 tout", tout_o, VEC[i][1]);
      chk("R6 irq", irq_o, VEC[i][0]);
    end
    chk("R7 no ovf on CR0 restart", ovf_o, 0);

    // R10: running write to a running mode is ignored
    wr(2'd0, 16'h0005);
    step(1, 0, 0);
    chk("R10 still match mode", count_o, 3);
    step(1, 0, 0);
    chk("R10 R5 restart", count_o, 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    chk("R10 count", count_o, 3);
    wr(2'd0, 16'h0001);   // stop is accepted
    step(0, 0, 0);
    chk("R10 stop accepted", count_o, 0);

    // R4: trigger restart, clear wins over tick
    wr(2'd1, 16'h0010); wr(2'd2, 16'h0020); wr(2'd0, 16'h0009);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    chk("R4 count", count_o, 3);
    chk("R4 tout before", tout_o, 1);
    step(1, 1, 0);
    chk("R4 cleared", count_o, 0);
    chk("R4 tout toggled", tout_o, 0);
    chk("R4 no irq", irq_o, 0);
    step(1, 0, 0);
    chk("R4 counts again", count_o, 1);

    // R9: capture on both registers, free-running
    wr(2'd0, 16'h0001); wr(2'd0, 16'h0035);
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    chk("R9 count", count_o, 5);
    step(0, 1, 0);
    chk("R9 cr0 captured", cr0_o, 5);
    chk("R9 irq waits for tick", irq_o, 0);
    step(1, 0, 0);
    chk("R9 irq on tick", irq_o, 1);
    step(0, 0, 0);
    chk("R9 irq one cycle", irq_o, 0);
    step(1, 0, 1);
    chk("R9 cr1 captured", cr1_o, 6);
    chk("R9 count", count_o, 7);
    chk("R9 irq not yet", irq_o, 0);
    step(1, 0, 0);
    chk("R9 irq for cr1", irq_o, 1);

    // R3/R7/R8: free-running rollover and overflow clear
    wr(2'd0, 16'h0001); wr(2'd0, 16'h0005);
    cnt_tick = 1'b1;
    repeat (65535) @(posedge clk);
    #1 cnt_tick = 1'b0;
    chk("R3 count top", count_o, 16'hFFFF);
    chk("R7 ovf not yet", ovf_o, 0);
    step(1, 0, 0);
    chk("R3 wrap", count_o, 0);
    chk("R7 ovf set", ovf_o, 1);
    wr(2'd0, 16'h0004);
    chk("R8 clear overridden", ovf_o, 1);
    step(1, 0, 0);
    chk("R8 count", count_o, 1);
    wr(2'd0, 16'h0005);
    chk("R8 write one no effect", ovf_o, 1);
    wr(2'd0, 16'h0004);
    chk("R8 cleared", ovf_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule